// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the running wall-clock time and date of a real-time clock: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Each one-second tick moves it forward by one second, with all carries through the calendar, including month lengths and leap years. A tick only takes effect when the three-bit oscillator-control field carries the single run code. In every other case the count is frozen.

The count is held internally as plain binary counters. Software-facing fields are converted on the way in and on the way out. Two mode inputs select the register encoding:
- one picks packed BCD or straight binary;
- the other picks 24-hour or 12-hour presentation of the hour, with an afternoon flag in bit 7.

A load strobe replaces the whole time and date from register-format fields in one cycle. The host bus and the interrupt logic sit outside this block.

Top module: `rtc_calendar_counter`

## Requirements
- R1: After a synchronous active-low reset, with BCD 24-hour encoding, the outputs read second 0x00, minute 0x00, hour 0x00, weekday 0x01, day 0x01, month 0x01, year 0x00.
- R2: A tick advances the count by one second only when the oscillator-control input equals 3'b010. A tick with any other code leaves every field unchanged.
- R3: Seconds and minutes count 0 to 59 and wrap to 0 with a carry. Hours count 0 to 23 and wrap to 0 with a carry into the day.
- R4: Days per month are 31 for January, March, May, July, August, October and December. They are 30 for April, June, September and November, and 28 for February in a common year. Passing the last day of a month gives day 1 of the next month, and December 31 rolls to January 1 of the next year.
- R5: February has 29 days when the full year, CENTURY*100 plus the two-digit year, is divisible by 4 and is either not divisible by 100 or divisible by 400. With the default CENTURY of 20, years 00 and 04 are leap years and 01 is not.
- R6: The weekday field runs 1 to 7, advances on each day change, and wraps from 7 to 1. The month field runs 1 to 12.
- R7: With bin_mode_i high, every field is plain binary. With it low, every field is packed BCD, tens digit in bits 7:4 and units in bits 3:0.
- R8: With h24_mode_i low, the hour output is the hour modulo 12 in bits 6:0, with bit 7 set for hours 12 to 23. On load in that mode, bits 6:0 are decoded and 12 is added when bit 7 is set.
- R9: The year field wraps from 99 to 00 when December 31 rolls over.
- R10: A load strobe takes priority over a tick in the same cycle, and a load takes effect whatever the oscillator-control code.
- R11: The count is stored in binary. Changing bin_mode_i or h24_mode_i re-encodes the outputs at once without changing the stored time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| osc_ctl_i | input | 3 | Oscillator-control field; only 3'b010 lets ticks count |
| bin_mode_i | input | 1 | 1: binary fields, 0: packed BCD fields |
| h24_mode_i | input | 1 | 1: 24-hour hour field, 0: 12-hour with PM in bit 7 |
| load_i | input | 1 | Load all fields from the ld_* inputs |
| ld_sec_i | input | 8 | Seconds to load, register encoding |
| ld_min_i | input | 8 | Minutes to load |
| ld_hour_i | input | 8 | Hour to load |
| ld_wday_i | input | 8 | Weekday to load, 1 to 7 |
| ld_mday_i | input | 8 | Day of month to load |
| ld_mon_i | input | 8 | Month to load, 1 to 12 |
| ld_year_i | input | 8 | Two-digit year to load |
| sec_o | output | 8 | Seconds, register encoding |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour |
| wday_o | output | 8 | Weekday |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The bench aims at the carry chain at its extremes. A single tick at 23:59:59 on December 31 of year 99 has to ripple through every field. A missed or extra carry shows up as a wrong day, month or year, or as a weekday stuck at 8 or 0.

February is tried in years 00, 01 and 04. A design using the plain divisible-by-4 rule gives the right answer for these at the default century. A design that treats year 00 as a century non-leap year jumps to March early. A swapped month length lands on the wrong day.

The 12-hour path is exercised across 11:59:59 in both the morning and the evening. A wrong modulo or flag gives 0x12 instead of 0x80, or loses the PM bit. Oscillator codes next to the run code are checked so that a decoder looking at only some of the bits is caught. A tick coinciding with a load catches a design that lets the advance win over the load.

// File: rtl/rtc_cal_pkg.sv
// Package: shared time type and register-encoding conversion helpers.
// Assumes register fields are 8 bits and BCD inputs hold valid digits.
package rtc_cal_pkg;

    localparam int FIELD_W = 8;

    // Binary time state; month and weekday are zero-based internally.
    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    // Register encoding to binary value.
    function automatic logic [7:0] reg_to_bin(input logic [7:0] v, input logic bin);
        if (bin) return v;
        return 8'(v[7:4]) * 8'd10 + 8'(v[3:0]);
    endfunction

    // Binary value to register encoding.
    function automatic logic [7:0] bin_to_reg(input logic [7:0] v, input logic bin);
        logic [7:0] tens;
        logic [7:0] ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        if (bin) return v;
        return {4'(tens), 4'(ones)};
    endfunction

endpackage

// File: rtl/rtc_cal_decode.sv
// Converts register-format load fields into the binary time state.
// Assumes in-range values; out-of-range inputs are truncated to field width.
module rtc_cal_decode
    import rtc_cal_pkg::*;
(
    input  logic [FIELD_W-1:0] sec_i,
    input  logic [FIELD_W-1:0] min_i,
    input  logic [FIELD_W-1:0] hour_i,
    input  logic [FIELD_W-1:0] wday_i,
    input  logic [FIELD_W-1:0] mday_i,
    input  logic [FIELD_W-1:0] mon_i,
    input  logic [FIELD_W-1:0] year_i,
    input  logic               bin_mode_i,
    input  logic               h24_mode_i,
    output cal_time_t          time_o
);

    logic [7:0] hour_b;
    logic [7:0] wday_b;
    logic [7:0] mon_b;

    // Decode each field; the hour applies the PM offset in 12-hour mode.
    always_comb begin
        hour_b = reg_to_bin({1'b0, hour_i[6:0]}, bin_mode_i);
        if (!h24_mode_i && hour_i[7]) hour_b = hour_b + 8'd12;
        wday_b = reg_to_bin(wday_i, bin_mode_i) - 8'd1;
        mon_b  = reg_to_bin(mon_i, bin_mode_i) - 8'd1;
        time_o.sec  = 6'(reg_to_bin(sec_i, bin_mode_i));
        time_o.min  = 6'(reg_to_bin(min_i, bin_mode_i));
        time_o.hour = 5'(hour_b);
        time_o.wday = 3'(wday_b);
        time_o.mday = 5'(reg_to_bin(mday_i, bin_mode_i));
        time_o.mon  = 4'(mon_b);
        time_o.year = 7'(reg_to_bin(year_i, bin_mode_i));
    end

endmodule

// File: rtl/rtc_cal_step.sv
// Computes the time one second after the current binary time.
// Assumes the full year is CENTURY*100 + year; since 100 is a multiple of 4,
// only year 00 needs the century term of the leap rule.
module rtc_cal_step
    import rtc_cal_pkg::*;
#(
    parameter int CENTURY = 20
) (
    input  cal_time_t cur_i,
    output cal_time_t nxt_o
);

    localparam logic CENT_LEAP = ((CENTURY % 4) == 0);

    logic       leap;
    logic [4:0] month_len;

    // Leap flag and length of the current month.
    always_comb begin
        leap = (cur_i.year[1:0] == 2'b00) && ((cur_i.year != 7'd0) || CENT_LEAP);
        case (cur_i.mon)
            4'd1:                     month_len = leap ? 5'd29 : 5'd28;
            4'd3, 4'd5, 4'd8, 4'd10:  month_len = 5'd30;
            default:                  month_len = 5'd31;
        endcase
    end

    // Ripple the one-second increment through all fields.
    always_comb begin
        nxt_o = cur_i;
        if (cur_i.sec < 6'd59) begin
            nxt_o.sec = cur_i.sec + 6'd1;
        end else begin
            nxt_o.sec = 6'd0;
            if (cur_i.min < 6'd59) begin
                nxt_o.min = cur_i.min + 6'd1;
            end else begin
                nxt_o.min = 6'd0;
                if (cur_i.hour < 5'd23) begin
                    nxt_o.hour = cur_i.hour + 5'd1;
                end else begin
                    nxt_o.hour = 5'd0;
                    nxt_o.wday = (cur_i.wday >= 3'd6) ? 3'd0 : cur_i.wday + 3'd1;
                    if (cur_i.mday == 5'd0) begin
                        nxt_o.mday = 5'd1;
                    end else if (cur_i.mday < month_len) begin
                        nxt_o.mday = cur_i.mday + 5'd1;
                    end else begin
                        nxt_o.mday = 5'd1;
                        if (cur_i.mon < 4'd11) begin
                            nxt_o.mon = cur_i.mon + 4'd1;
                        end else begin
                            nxt_o.mon  = 4'd0;
                            nxt_o.year = (cur_i.year >= 7'd99) ? 7'd0 : cur_i.year + 7'd1;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rtc_cal_encode.sv
// Presents the binary time state in register encoding for the current modes.
// Assumes the state is in range; weekday and month gain their +1 offset here.
module rtc_cal_encode
    import rtc_cal_pkg::*;
(
    input  cal_time_t          time_i,
    input  logic               bin_mode_i,
    input  logic               h24_mode_i,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] hour_o,
    output logic [FIELD_W-1:0] wday_o,
    output logic [FIELD_W-1:0] mday_o,
    output logic [FIELD_W-1:0] mon_o,
    output logic [FIELD_W-1:0] year_o
);

    logic       pm;
    logic [7:0] hour_v;
    logic [7:0] hour_r;

    // Encode the plain fields.
    always_comb begin
        sec_o  = bin_to_reg(8'(time_i.sec), bin_mode_i);
        min_o  = bin_to_reg(8'(time_i.min), bin_mode_i);
        wday_o = bin_to_reg(8'(time_i.wday) + 8'd1, bin_mode_i);
        mday_o = bin_to_reg(8'(time_i.mday), bin_mode_i);
        mon_o  = bin_to_reg(8'(time_i.mon) + 8'd1, bin_mode_i);
        year_o = bin_to_reg(8'(time_i.year), bin_mode_i);
    end

    // Encode the hour, folding to 12-hour form with a PM flag when selected.
    always_comb begin
        pm     = (time_i.hour >= 5'd12);
        hour_v = 8'(time_i.hour);
        if (!h24_mode_i && pm) hour_v = hour_v - 8'd12;
        hour_r = bin_to_reg(hour_v, bin_mode_i);
        hour_o = h24_mode_i ? hour_r : {pm, 7'(hour_r)};
    end

endmodule

// File: rtl/rtc_calendar_counter.sv
// Top: time/date register with load, gated one-second advance and encoding.
// Assumes tick_i is a single-cycle pulse; load wins over a coincident tick.
module rtc_calendar_counter
    import rtc_cal_pkg::*;
#(
    parameter int           CENTURY  = 20,
    parameter int           OSC_W    = 3,
    parameter logic [OSC_W-1:0] RUN_CODE = 3'b010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [OSC_W-1:0]   osc_ctl_i,
    input  logic               bin_mode_i,
    input  logic               h24_mode_i,
    input  logic               load_i,
    input  logic [FIELD_W-1:0] ld_sec_i,
    input  logic [FIELD_W-1:0] ld_min_i,
    input  logic [FIELD_W-1:0] ld_hour_i,
    input  logic [FIELD_W-1:0] ld_wday_i,
    input  logic [FIELD_W-1:0] ld_mday_i,
    input  logic [FIELD_W-1:0] ld_mon_i,
    input  logic [FIELD_W-1:0] ld_year_i,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] hour_o,
    output logic [FIELD_W-1:0] wday_o,
    output logic [FIELD_W-1:0] mday_o,
    output logic [FIELD_W-1:0] mon_o,
    output logic [FIELD_W-1:0] year_o
);

    localparam cal_time_t RESET_TIME = '{year: 7'd0, mon: 4'd0, mday: 5'd1, wday: 3'd0,
                                         hour: 5'd0, min: 6'd0, sec: 6'd0};

    cal_time_t cur_q;
    cal_time_t load_val;
    cal_time_t next_val;
    logic      advance;

    assign advance = tick_i && (osc_ctl_i == RUN_CODE);

    rtc_cal_decode u_decode (
        .sec_i      (ld_sec_i),
        .min_i      (ld_min_i),
        .hour_i     (ld_hour_i),
        .wday_i     (ld_wday_i),
        .mday_i     (ld_mday_i),
        .mon_i      (ld_mon_i),
        .year_i     (ld_year_i),
        .bin_mode_i (bin_mode_i),
        .h24_mode_i (h24_mode_i),
        .time_o     (load_val)
    );

    rtc_cal_step #(.CENTURY(CENTURY)) u_step (
        .cur_i (cur_q),
        .nxt_o (next_val)
    );

    // Time state register: reset, then load over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_q <= RESET_TIME;
        else if (load_i)  cur_q <= load_val;
        else if (advance) cur_q <= next_val;
    end

    rtc_cal_encode u_encode (
        .time_i     (cur_q),
        .bin_mode_i (bin_mode_i),
        .h24_mode_i (h24_mode_i),
        .sec_o      (sec_o),
        .min_o      (min_o),
        .hour_o     (hour_o),
        .wday_o     (wday_o),
        .mday_o     (mday_o),
        .mon_o      (mon_o),
        .year_o     (year_o)
    );

endmodule

// File: rtl/rtc_calendar_counter_chk.sv
// Checker bound to the top: temporal properties on the stored time and outputs.
module rtc_calendar_counter_chk
    import rtc_cal_pkg::*;
#(
    parameter int               OSC_W    = 3,
    parameter logic [OSC_W-1:0] RUN_CODE = 3'b010
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic [OSC_W-1:0]   osc_ctl_i,
    input logic               load_i,
    input logic               bin_mode_i,
    input logic               h24_mode_i,
    input logic [FIELD_W-1:0] ld_sec_i,
    input logic [FIELD_W-1:0] sec_o,
    input logic [FIELD_W-1:0] hour_o,
    input cal_time_t          cur_q
);

    // Without load or a permitted tick the stored time holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(tick_i && osc_ctl_i == RUN_CODE)) |=> $stable(cur_q));

    // A permitted tick moves seconds by one, wrapping after 59.
    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tick_i && osc_ctl_i == RUN_CODE) |=>
        cur_q.sec == (($past(cur_q.sec) == 6'd59) ? 6'd0 : $past(cur_q.sec) + 6'd1));

    // Minutes only move on a seconds wrap.
    p_min_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cur_q.sec != 6'd59) |=> cur_q.min == $past(cur_q.min));

    // Load wins: in binary 24-hour mode the loaded seconds appear unchanged.
    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && bin_mode_i && h24_mode_i) |=>
        (!bin_mode_i || !h24_mode_i || sec_o == $past(ld_sec_i)));

    // In 12-hour mode bit 7 of the hour flags the afternoon.
    p_pm_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !h24_mode_i |-> (hour_o[7] == (cur_q.hour >= 5'd12)));

endmodule

bind rtc_calendar_counter rtc_calendar_counter_chk #(.OSC_W(OSC_W), .RUN_CODE(RUN_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .osc_ctl_i  (osc_ctl_i),
    .load_i     (load_i),
    .bin_mode_i (bin_mode_i),
    .h24_mode_i (h24_mode_i),
    .ld_sec_i   (ld_sec_i),
    .sec_o      (sec_o),
    .hour_o     (hour_o),
    .cur_q      (cur_q)
);

// File: tb/rtc_calendar_counter_tb.sv
module rtc_calendar_counter_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [2:0] osc_ctl_i = 3'b010;
    logic       bin_mode_i = 1'b0;
    logic       h24_mode_i = 1'b1;
    logic       load_i = 1'b0;
    logic [7:0] ld_sec_i = '0, ld_min_i = '0, ld_hour_i = '0, ld_wday_i = '0;
    logic [7:0] ld_mday_i = '0, ld_mon_i = '0, ld_year_i = '0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rtc_calendar_counter u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .osc_ctl_i(osc_ctl_i),
        .bin_mode_i(bin_mode_i), .h24_mode_i(h24_mode_i), .load_i(load_i),
        .ld_sec_i(ld_sec_i), .ld_min_i(ld_min_i), .ld_hour_i(ld_hour_i),
        .ld_wday_i(ld_wday_i), .ld_mday_i(ld_mday_i), .ld_mon_i(ld_mon_i),
        .ld_year_i(ld_year_i),
        .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
        .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o)
    );

    task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", what, got, exp);
        end
    endtask

    // Present load fields and strobe for one cycle (optionally with a tick).
    task automatic do_load(input logic [7:0] s, m, h, wd, md, mo, yr, input logic with_tick);
        @(negedge clk);
        ld_sec_i = s; ld_min_i = m; ld_hour_i = h; ld_wday_i = wd;
        ld_mday_i = md; ld_mon_i = mo; ld_year_i = yr;
        load_i = 1'b1; tick_i = with_tick;
        @(negedge clk);
        load_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sec", sec_o, 8'h00);   chk("R1 min", min_o, 8'h00);
        chk("R1 hour", hour_o, 8'h00); chk("R1 wday", wday_o, 8'h01);
        chk("R1 mday", mday_o, 8'h01); chk("R1 mon", mon_o, 8'h01);
        chk("R1 year", year_o, 8'h00);
    endtask

    task automatic t_osc_gate();
        do_load(8'h30, 8'h20, 8'h10, 8'h02, 8'h05, 8'h03, 8'h21, 1'b0);
        osc_ctl_i = 3'b000; do_tick(); chk("R2 code 000", sec_o, 8'h30);
        osc_ctl_i = 3'b110; do_tick(); chk("R2 code 110", sec_o, 8'h30);
        osc_ctl_i = 3'b011; do_tick(); chk("R2 code 011", sec_o, 8'h30);
        osc_ctl_i = 3'b010; do_tick(); chk("R2 code 010", sec_o, 8'h31);
        @(negedge clk); chk("R2 no tick", sec_o, 8'h31);
    endtask

    task automatic t_year_end();
        do_load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 1'b0);
        do_tick();
        chk("R3 sec", sec_o, 8'h00); chk("R3 min", min_o, 8'h00);
        chk("R3 hour", hour_o, 8'h00); chk("R6 wday wrap", wday_o, 8'h01);
        chk("R4 mday", mday_o, 8'h01); chk("R4 mon", mon_o, 8'h01);
        chk("R9 year wrap", year_o, 8'h00);
    endtask

    task automatic t_month_ends();
        do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00, 1'b0); do_tick();
        chk("R5 yr00 day", mday_o, 8'h29); chk("R5 yr00 mon", mon_o, 8'h02);
        chk("R6 wday step", wday_o, 8'h02);
        do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00, 1'b0); do_tick();
        chk("R5 feb29 day", mday_o, 8'h01); chk("R5 feb29 mon", mon_o, 8'h03);
        do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h01, 1'b0); do_tick();
        chk("R5 yr01 day", mday_o, 8'h01); chk("R5 yr01 mon", mon_o, 8'h03);
        do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h04, 1'b0); do_tick();
        chk("R5 yr04 day", mday_o, 8'h29);
        do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21, 1'b0); do_tick();
        chk("R4 apr30 day", mday_o, 8'h01); chk("R4 apr30 mon", mon_o, 8'h05);
        do_load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h21, 1'b0); do_tick();
        chk("R4 jan30 day", mday_o, 8'h31); chk("R4 jan30 mon", mon_o, 8'h01);
    endtask

    task automatic t_binary();
        @(negedge clk); bin_mode_i = 1'b1;
        do_load(8'h3B, 8'h3B, 8'h10, 8'h02, 8'h1F, 8'h01, 8'h63, 1'b0); do_tick();
        chk("R7 bin sec", sec_o, 8'h00); chk("R7 bin min", min_o, 8'h00);
        chk("R7 bin hour", hour_o, 8'h11); chk("R7 bin year", year_o, 8'h63);
        @(negedge clk); bin_mode_i = 1'b0; #1;
        chk("R11 bcd hour", hour_o, 8'h17); chk("R11 bcd mday", mday_o, 8'h31);
        chk("R11 bcd year", year_o, 8'h99);
    endtask

    task automatic t_twelve_hour();
        @(negedge clk); h24_mode_i = 1'b0;
        do_load(8'h59, 8'h59, 8'h91, 8'h03, 8'h15, 8'h06, 8'h21, 1'b0);
        chk("R8 pm load", hour_o, 8'h91);
        do_tick();
        chk("R8 midnight", hour_o, 8'h00); chk("R8 day", mday_o, 8'h16);
        chk("R6 wday", wday_o, 8'h04);
        do_load(8'h59, 8'h59, 8'h11, 8'h03, 8'h15, 8'h06, 8'h21, 1'b0); do_tick();
        chk("R8 noon", hour_o, 8'h80);
        @(negedge clk); h24_mode_i = 1'b1; #1;
        chk("R11 noon 24h", hour_o, 8'h12);
    endtask

    task automatic t_priority();
        osc_ctl_i = 3'b010;
        do_load(8'h45, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10, 1'b1);
        chk("R10 load over tick", sec_o, 8'h45);
        osc_ctl_i = 3'b000;
        do_load(8'h07, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h10, 1'b0);
        chk("R10 load while stopped", sec_o, 8'h07);
        osc_ctl_i = 3'b010;
    endtask

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_osc_gate();
        t_year_end();
        t_month_ends();
        t_binary();
        t_twelve_hour();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule